// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block maps a 16-bit virtual address onto a wider physical address through a small on-chip set of segment descriptors. The upper four address bits pick one of sixteen descriptors, and the lower twelve bits are an offset into that segment. Each descriptor holds three things:

- a physical base;
- an inclusive physical upper limit;
- a three-bit rights mask.

Each request carries an operation type: read, write or instruction fetch. The unit adds the offset to the selected base. It then checks the result against the limit, and checks the operation against the rights mask. The outcome is either a relocated address or a fault with a cause code.

Translation is combinational inside the block. The result leaves through registers one clock after the request. Software reloads descriptors through a simple write port, typically when the running process changes. A descriptor write is visible to requests presented on the next cycle.

After reset every descriptor grants no rights, so every access faults until software loads the table.

Top module: `seg_xlate`

## Requirements
- R1: Virtual bits [15:12] select the descriptor and bits [11:0] are the offset. For a permitted, in-limit access, `rsp_paddr` equals base plus offset, and `rsp_valid` is high one cycle after `req_valid`.
- R2: If base plus offset is strictly greater than the descriptor limit, the response has `rsp_fault`=1, `rsp_cause`=2'b01 (limit fault) and `rsp_paddr`=0. A result equal to the limit is allowed.
- R3: The rights mask is decoded as follows: bit0 allows read, bit1 allows write, bit2 allows fetch, and 3'b000 means no access. The operation codes are `req_op` 2'b00 read, 2'b01 write and 2'b10 fetch. Code 2'b11 is never permitted. An access whose operation is not permitted gives `rsp_fault`=1, `rsp_cause`=2'b10 (rights fault) and `rsp_paddr`=0.
- R4: When an access breaks both the rights and the limit, the rights fault is reported. `rsp_cause` is never 2'b11, and `rsp_fault` is high exactly when `rsp_cause` is nonzero.
- R5: If base plus offset carries out of the physical address width, the access is a limit fault (cause 2'b01).
- R6: Synchronous active-high reset clears the response outputs to zero and sets every descriptor's rights to 3'b000, so any access after reset is a rights fault.
- R7: A descriptor write applies to requests presented on the following cycle and later. A request presented in the same cycle as the write sees the old descriptor.
- R8: When `req_valid` is low, the next cycle shows `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_paddr` all zero.
- R9: A descriptor with base 10000, limit 11000 and read rights, accessed for read at offset 120, yields physical address 10120 with no fault.
- R10: Writing one descriptor leaves the translations of all other descriptors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 16 | Virtual address |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 fetch, 11 reserved |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 4 | Descriptor number to write |
| cfg_base | input | 20 | Physical base of the descriptor |
| cfg_limit | input | 20 | Inclusive physical upper limit |
| cfg_rights | input | 3 | Rights mask: bit0 read, bit1 write, bit2 fetch |
| rsp_valid | output | 1 | Registered result valid |
| rsp_fault | output | 1 | Registered fault flag |
| rsp_cause | output | 2 | 00 none, 01 limit, 10 rights |
| rsp_paddr | output | 20 | Relocated physical address, zero on fault |

## Verification
The assertions assume that `req_op` and `req_valid` are always driven to known values, and that reset is held for at least one clock before traffic starts. They place no restriction on descriptor contents or on write timing.

The stimulus changes inputs only on the falling clock edge, so both rules hold. Random descriptors draw limits both above and below their bases, and bases near the top of the physical range, so that limit faults and carry-out appear alongside clean translations.

Directed cases cover the exact-limit edge, the reserved operation code and a write that collides with a request.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_FETCH = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_LIMIT = 2'b01,
    CAUSE_PROT  = 2'b10
  } cause_e;

  localparam int RIGHTS_W = 3;
  localparam int RT_READ  = 0;
  localparam int RT_WRITE = 1;
  localparam int RT_FETCH = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int NSEG  = 16,
  parameter int IDX_W = 4,
  parameter int PA_W  = 20
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [PA_W-1:0]               wr_base,
  input  logic [PA_W-1:0]               wr_limit,
  input  logic [seg_pkg::RIGHTS_W-1:0]  wr_rights,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [PA_W-1:0]               rd_base,
  output logic [PA_W-1:0]               rd_limit,
  output logic [seg_pkg::RIGHTS_W-1:0]  rd_rights
);

  // base and limit: plain RAM without reset (distributed RAM inference)
  logic [PA_W-1:0] base_mem  [NSEG];
  logic [PA_W-1:0] limit_mem [NSEG];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_mem[wr_idx]  <= wr_base;
      limit_mem[wr_idx] <= wr_limit;
    end
  end

  // rights: flops with reset so the table starts out denying everything
  logic [seg_pkg::RIGHTS_W-1:0] rights_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_rights
    always_ff @(posedge clk) begin
      if (rst) begin
        rights_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        rights_q[g] <= wr_rights;
      end
    end
  end

  assign rd_base   = base_mem[rd_idx];
  assign rd_limit  = limit_mem[rd_idx];
  assign rd_rights = rights_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int PA_W  = 20,
  parameter int OFF_W = 12
) (
  input  logic [PA_W-1:0]               base,
  input  logic [PA_W-1:0]               limit,
  input  logic [seg_pkg::RIGHTS_W-1:0]  rights,
  input  logic [OFF_W-1:0]              offset,
  input  logic [1:0]                    op,
  output logic                          fault,
  output seg_pkg::cause_e               cause,
  output logic [PA_W-1:0]               paddr
);
  import seg_pkg::*;

  localparam int SUM_W = PA_W + 1;

  logic [SUM_W-1:0] sum;
  logic             allowed;
  logic             over;

  assign sum = {1'b0, base} + {{(SUM_W-OFF_W){1'b0}}, offset};

  always_comb begin
    unique case (op)
      OP_READ:  allowed = rights[RT_READ];
      OP_WRITE: allowed = rights[RT_WRITE];
      OP_FETCH: allowed = rights[RT_FETCH];
      default:  allowed = 1'b0;
    endcase
  end

  assign over = sum[PA_W] || (sum[PA_W-1:0] > limit);

  always_comb begin
    if (!allowed) begin
      cause = CAUSE_PROT;
    end else if (over) begin
      cause = CAUSE_LIMIT;
    end else begin
      cause = CAUSE_NONE;
    end
    fault = (cause != CAUSE_NONE);
    paddr = fault ? '0 : sum[PA_W-1:0];
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W  = 16,
  parameter int SEG_W = 4,
  parameter int PA_W  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_op,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [PA_W-1:0]  cfg_limit,
  input  logic [2:0]       cfg_rights,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  import seg_pkg::*;

  localparam int OFF_W = VA_W - SEG_W;
  localparam int NSEG  = 1 << SEG_W;

  logic [SEG_W-1:0]    seg_sel;
  logic [OFF_W-1:0]    seg_off;
  logic [PA_W-1:0]     d_base;
  logic [PA_W-1:0]     d_limit;
  logic [RIGHTS_W-1:0] d_rights;
  logic                c_fault;
  cause_e              c_cause;
  logic [PA_W-1:0]     c_paddr;

  assign seg_sel = req_vaddr[VA_W-1:OFF_W];
  assign seg_off = req_vaddr[OFF_W-1:0];

  seg_table #(
    .NSEG (NSEG),
    .IDX_W(SEG_W),
    .PA_W (PA_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .wr_rights(cfg_rights),
    .rd_idx   (seg_sel),
    .rd_base  (d_base),
    .rd_limit (d_limit),
    .rd_rights(d_rights)
  );

  seg_check #(
    .PA_W (PA_W),
    .OFF_W(OFF_W)
  ) u_check (
    .base  (d_base),
    .limit (d_limit),
    .rights(d_rights),
    .offset(seg_off),
    .op    (req_op),
    .fault (c_fault),
    .cause (c_cause),
    .paddr (c_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'b00;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_fault <= c_fault;
      rsp_cause <= c_cause;
      rsp_paddr <= c_paddr;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic [PA_W-1:0] rsp_paddr
);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R1

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst) (rsp_cause == 2'b01) |-> (rsp_paddr == '0)); // R2

  AST_RSVD_OP_PROT: assert property (@(posedge clk) disable iff (rst) (req_valid && req_op == 2'b11) |=> (rsp_fault && rsp_cause == 2'b10)); // R3

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst) (rsp_cause != 2'b11) && (rsp_fault == (rsp_cause != 2'b00))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 2'b00 && rsp_paddr == '0)); // R8

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_op   (req_op),
  .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause),
  .rsp_paddr(rsp_paddr)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
  localparam int PA_W = 20;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic [15:0]     req_vaddr;
  logic [1:0]      req_op;
  logic            cfg_we;
  logic [3:0]      cfg_idx;
  logic [PA_W-1:0] cfg_base;
  logic [PA_W-1:0] cfg_limit;
  logic [2:0]      cfg_rights;
  logic            rsp_valid;
  logic            rsp_fault;
  logic [1:0]      rsp_cause;
  logic [PA_W-1:0] rsp_paddr;

  always #2.5 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_op(req_op),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_rights(cfg_rights), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  logic [PA_W-1:0] m_base  [16];
  logic [PA_W-1:0] m_limit [16];
  logic [2:0]      m_rights[16];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  function automatic logic [1:0] exp_cause(logic [15:0] va, logic [1:0] op);
    logic [PA_W:0] s;
    logic ok;
    s = {1'b0, m_base[va[15:12]]} + (PA_W+1)'(va[11:0]);
    case (op)
      2'b00: ok = m_rights[va[15:12]][0];
      2'b01: ok = m_rights[va[15:12]][1];
      2'b10: ok = m_rights[va[15:12]][2];
      default: ok = 1'b0;
    endcase
    if (!ok) return 2'b10;
    if (s[PA_W] || s[PA_W-1:0] > m_limit[va[15:12]]) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [PA_W-1:0] exp_paddr(logic [15:0] va, logic [1:0] op);
    if (exp_cause(va, op) != 2'b00) return '0;
    return m_base[va[15:12]] + PA_W'(va[11:0]);
  endfunction

  task automatic check(string rq, logic [PA_W+3:0] act, logic [PA_W+3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic put_desc(int idx, logic [PA_W-1:0] b, logic [PA_W-1:0] l, logic [2:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_base = b; cfg_limit = l; cfg_rights = r;
    @(posedge clk);
    m_base[idx] = b; m_limit[idx] = l; m_rights[idx] = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request; checks the registered response after the next rising edge
  task automatic xlate(string rq, logic [15:0] va, logic [1:0] op);
    logic [1:0] ec;
    logic [PA_W-1:0] ep;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_op = op;
    ec = exp_cause(va, op);
    ep = exp_paddr(va, op);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(rq, {1'b0, rsp_valid, rsp_fault, rsp_cause, rsp_paddr} >> 0,
          {1'b0, 1'b1, (ec != 2'b00), ec, ep});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1'b1; req_valid = 0; req_vaddr = 0; req_op = 0;
    cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0; cfg_rights = 0;
    for (int i = 0; i < 16; i++) begin m_base[i] = 'x; m_limit[i] = 'x; m_rights[i] = 3'b000; end
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset outputs", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, '0);
    @(negedge clk); rst = 1'b0;

    // R6: all segments deny after reset
    for (int i = 0; i < 16; i++) begin
      for (int o = 0; o < 3; o++) begin
        @(negedge clk);
        req_valid = 1; req_vaddr = {4'(i), 12'h123}; req_op = 2'(o);
        @(posedge clk); #1; req_valid = 0;
        check("R6 reset rights fault", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr},
              {1'b1, 1'b1, 2'b10, PA_W'(0)});
      end
    end

    // give all descriptors known content
    for (int i = 0; i < 16; i++) put_desc(i, PA_W'(i * 4096), PA_W'(i * 4096 + 4095), 3'b111);

    // R9 worked example
    put_desc(3, PA_W'(10000), PA_W'(11000), 3'b001);
    xlate("R9 example", {4'd3, 12'd120}, 2'b00);
    check("R9 paddr", rsp_paddr, PA_W'(10120));
    // R2 limit edge
    xlate("R2 equal limit", {4'd3, 12'd1000}, 2'b00);
    xlate("R2 limit plus one", {4'd3, 12'd1001}, 2'b00);
    check("R2 cause", rsp_cause, 2'b01);
    // R3 rights per op
    xlate("R3 write denied", {4'd3, 12'd5}, 2'b01);
    xlate("R3 fetch denied", {4'd3, 12'd5}, 2'b10);
    put_desc(4, PA_W'(2000), PA_W'(6000), 3'b110);
    xlate("R3 write allowed", {4'd4, 12'd7}, 2'b01);
    xlate("R3 fetch allowed", {4'd4, 12'd7}, 2'b10);
    xlate("R3 read denied", {4'd4, 12'd7}, 2'b00);
    xlate("R3 reserved op", {4'd4, 12'd7}, 2'b11);
    // R4 both violations -> rights
    xlate("R4 prot over limit", {4'd3, 12'hfff}, 2'b01);
    check("R4 cause", rsp_cause, 2'b10);
    // R5 carry out
    put_desc(5, PA_W'(20'hfff00), PA_W'(20'hfffff), 3'b111);
    xlate("R5 carry out", {4'd5, 12'h200}, 2'b00);
    check("R5 cause", rsp_cause, 2'b01);
    xlate("R5 top no carry", {4'd5, 12'h0ff}, 2'b00);

    // R7 write and request in same cycle: old contents
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'd6; cfg_base = PA_W'(50000); cfg_limit = PA_W'(60000); cfg_rights = 3'b000;
    req_valid = 1; req_vaddr = {4'd6, 12'd10}; req_op = 2'b00;
    @(posedge clk); #1;
    req_valid = 0; cfg_we = 0;
    check("R7 same cycle old", {rsp_fault, rsp_paddr}, {1'b0, PA_W'(6 * 4096 + 10)});
    m_base[6] = PA_W'(50000); m_limit[6] = PA_W'(60000); m_rights[6] = 3'b000;
    xlate("R7 next cycle new", {4'd6, 12'd10}, 2'b00);
    // R10 neighbours untouched
    xlate("R10 neighbour 7", {4'd7, 12'd44}, 2'b10);
    xlate("R10 neighbour 5", {4'd5, 12'd1}, 2'b01);

    // R8 idle
    @(negedge clk); req_valid = 0; req_vaddr = 16'hffff; req_op = 2'b11;
    @(posedge clk); #1;
    check("R8 idle", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, '0);

    // random traffic (R1, R2, R3, R5)
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [PA_W-1:0] b;
        b = PA_W'($urandom);
        put_desc($urandom_range(0, 15), b, b + PA_W'($urandom_range(0, 5000)) - PA_W'(500),
                 3'($urandom));
      end
      xlate("R1 random", 16'($urandom), 2'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule